// File: doc/BRIEF.md
# Memory Playback Sequencer

This block reads stored samples out of a synchronous RAM and presents them on an output stream. The RAM itself is filled by other logic; this block only drives the RAM's read address and read enable, then forwards the returned word together with a valid flag.

There are two ways to play the memory. In the one-shot way, a mode write arms the block. A trigger then starts a programmable wait in clocks, after which exactly `length` words are read from address 0 upward, and the block falls back to idle. In the looping way, reading begins straight after the mode write and cycles over the first `length` addresses with no gap between passes. A write of the idle mode stops it at once. Only the looping play reacts to mode writes while it is running; a one-shot burst always runs to its end.

The delay and length are taken from the control inputs when a mode write starts an operation. The RAM answers one cycle after an address is issued, so the valid flag is delayed by that same cycle.

Top module: `playback_seq`

## Requirements
- R1: Mode codes on `mode_in` are 0 = idle, 1 = one-shot, 2 = loop; code 3 is ignored. Status codes on `status` are 0 = idle, 1 = armed, 2 = sending. After reset, status is 0 and `out_valid` and `ram_rd` are low.
- R2: A mode write of 1 with nonzero length sets status to 1 after the edge that samples it. No RAM read is issued until a trigger arrives. A trigger while idle has no effect.
- R3: If the trigger is sampled at edge t with delay D (15 bits, 0 to 32767), the first read is issued in the cycle after edge t+D. Status stays 1 until edge t+D.
- R4: A one-shot burst reads exactly `length` words from addresses 0, 1, … length-1 with status 2, then status returns to 0, and a new mode write of 1 re-arms the block.
- R5: `out_valid` is high in the cycle after each read cycle, and `out_data` then holds the RAM word of the address read.
- R6: A mode write of 2 with nonzero length starts reads in the next cycle with status 2. After address length-1 the address returns to 0 with no idle cycle.
- R7: In loop play, a mode write of 0 stops reads in the cycle that carries it; after that edge, status is 0 and `out_valid` is low.
- R8: While a one-shot operation is armed, waiting out its delay or sending, every mode write, including 0 and 2, is ignored.
- R9: A mode write of 1 or 2 with length 0 leaves status at 0, and no reads follow, even on a trigger.
- R10: The address is 11 bits wide. A length of 2048 covers the whole memory, and in loop play address 2047 is followed by address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_in | input | 2 | Mode code written |
| delay_in | input | 15 | One-shot delay in clocks |
| length_in | input | 12 | Words per burst or per loop pass (0 to 2048) |
| trigger | input | 1 | Starts an armed one-shot |
| ram_rd | output | 1 | RAM read enable |
| ram_addr | output | 11 | RAM read address |
| ram_data | input | 16 | RAM read data, one cycle after the address |
| out_data | output | 16 | Output sample |
| out_valid | output | 1 | Output sample valid |
| status | output | 2 | Operation status |

## Verification
The bench plays one-shot bursts whose delays run from 0 to the 15-bit maximum. A design that is off by one in the delay count would move the first read a cycle early or late. One that counts the length wrongly would emit one word too many or too few. The 2048-word cases catch a length compare that fails when the length's low 11 bits are all zero: such a design would stop at once or never stop. Loop play is checked for back-to-back data across the wrap and for a stop that leaves no trailing valid word. Mode writes during a one-shot check that a design which obeys them, and so aborts or restarts the burst, gets reported.

// File: rtl/playback_seq.sv
module playback_seq #(
  parameter int DW   = 16,
  parameter int AW   = 11,
  parameter int DLYW = 15,
  localparam int LW  = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_wr,
  input  logic [1:0]      mode_in,
  input  logic [DLYW-1:0] delay_in,
  input  logic [LW-1:0]   length_in,
  input  logic            trigger,
  output logic            ram_rd,
  output logic [AW-1:0]   ram_addr,
  input  logic [DW-1:0]   ram_data,
  output logic [DW-1:0]   out_data,
  output logic            out_valid,
  output logic [1:0]      status
);

  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_ARMED = 3'd1;
  localparam logic [2:0] S_WAIT  = 3'd2;
  localparam logic [2:0] S_SHOT  = 3'd3;
  localparam logic [2:0] S_LOOP  = 3'd4;

  logic [2:0]      state;
  logic [AW-1:0]   idx;
  logic [LW-1:0]   len_q;
  logic [DLYW-1:0] dly_q, dcnt;

  wire len_ok    = length_in != '0;
  wire wr_idle   = mode_wr && mode_in == 2'd0;
  wire wr_single = mode_wr && mode_in == 2'd1;
  wire wr_loop   = mode_wr && mode_in == 2'd2;
  wire stop_now  = state == S_LOOP && wr_idle;
  wire last      = idx == len_q[AW-1:0] - 1'b1;

  assign ram_rd   = (state == S_SHOT || state == S_LOOP) && !stop_now;
  assign ram_addr = idx;
  assign out_data = ram_data;
  assign status   = (state == S_SHOT || state == S_LOOP)  ? 2'd2 :
                    (state == S_ARMED || state == S_WAIT) ? 2'd1 : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= '0;
      len_q     <= '0;
      dly_q     <= '0;
      dcnt      <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= ram_rd;
      case (state)
        S_IDLE: begin
          idx <= '0;
          if (wr_single && len_ok) begin
            len_q <= length_in;
            dly_q <= delay_in;
            state <= S_ARMED;
          end else if (wr_loop && len_ok) begin
            len_q <= length_in;
            state <= S_LOOP;
          end
        end
        S_ARMED: if (trigger) begin
          if (dly_q == '0) state <= S_SHOT;
          else begin
            dcnt  <= dly_q;
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (dcnt == DLYW'(1)) state <= S_SHOT;
          else dcnt <= dcnt - 1'b1;
        end
        S_SHOT: begin
          idx <= idx + 1'b1;
          if (last) state <= S_IDLE;
        end
        S_LOOP: begin
          if (stop_now) state <= S_IDLE;
          else idx <= last ? '0 : idx + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/playback_seq_chk.sv
module playback_seq_chk #(
  parameter int AW = 11,
  localparam int LW = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_wr,
  input logic [1:0]    mode_in,
  input logic [LW-1:0] length_in,
  input logic          ram_rd,
  input logic [AW-1:0] ram_addr,
  input logic          out_valid,
  input logic [1:0]    status,
  input logic [2:0]    state
);

  assert_status_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'd3);

  assert_no_read_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'd1 |-> !ram_rd);

  assert_read_only_sending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd |-> status == 2'd2);

  assert_valid_follows_send_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(status) == 2'd2);

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd && $past(ram_rd)) |-> (ram_addr == $past(ram_addr) + 1'b1 || ram_addr == '0));

  assert_loop_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && mode_wr && mode_in == 2'd0) |=> (status == 2'd0 && !out_valid));

  assert_zero_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd0 && mode_wr && length_in == '0) |=> status == 2'd0);

endmodule

bind playback_seq playback_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
  .length_in(length_in), .ram_rd(ram_rd), .ram_addr(ram_addr),
  .out_valid(out_valid), .status(status), .state(state)
);

// File: tb/test_playback_seq.sv
`timescale 1ns/1ps
module test_playback_seq;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        mode_wr = 0;
  logic [1:0]  mode_in = 0;
  logic [14:0] delay_in = 0;
  logic [11:0] length_in = 0;
  logic        trigger = 0;
  logic        ram_rd;
  logic [10:0] ram_addr;
  logic [15:0] ram_q = 0;
  logic [15:0] out_data;
  logic        out_valid;
  logic [1:0]  status;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  playback_seq i_playback_seq (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
    .delay_in(delay_in), .length_in(length_in), .trigger(trigger),
    .ram_rd(ram_rd), .ram_addr(ram_addr), .ram_data(ram_q),
    .out_data(out_data), .out_valid(out_valid), .status(status)
  );

  function automatic logic [15:0] word(input int a);
    logic [31:0] p;
    p = a * 32'h9E37;
    return p[15:0] ^ 16'h5A5A;
  endfunction

  always @(posedge clk) if (ram_rd) ram_q <= word(int'(ram_addr));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic write_mode(input logic [1:0] m, input int d, input int l);
    @(negedge clk);
    mode_wr = 1; mode_in = m; delay_in = 15'(d); length_in = 12'(l);
    @(negedge clk);
    mode_wr = 0;
  endtask

  task automatic run_burst(input int d, input int l, input bit poke);
    int rd_first, first, cnt, bad, bad_stat, rd_err;
    write_mode(2'd1, d, l);
    check(status == 2'd1, "R2 armed", status, 1);
    rd_err = 0;
    repeat (3) begin @(negedge clk); if (ram_rd) rd_err++; end
    check(rd_err == 0, "R2 no read before trigger", rd_err, 0);
    if (poke) begin
      mode_wr = 1; mode_in = 2'd0; @(negedge clk);
      mode_in = 2'd2; length_in = 12'd9; @(negedge clk);
      mode_wr = 0;
      check(status == 2'd1, "R8 writes ignored while armed", status, 1);
    end
    trigger = 1; @(negedge clk); trigger = 0;
    rd_first = -1; first = -1; cnt = 0; bad = 0; bad_stat = 0;
    for (int k = 0; k < d + l + 4; k++) begin
      if (k > 0) @(negedge clk);
      if (poke && (k == d + 1 || k == d + 2)) begin mode_wr = 1; mode_in = 2'd0; end
      else mode_wr = 0;
      if (k < d && status != 2'd1) bad_stat++;
      if (ram_rd && rd_first < 0) rd_first = k;
      if (out_valid) begin
        if (first < 0) first = k;
        if (out_data != word(cnt)) bad++;
        cnt++;
      end
    end
    mode_wr = 0;
    check(rd_first == d, "R3 first read cycle", rd_first, d);
    check(bad_stat == 0, "R3 armed during delay", bad_stat, 0);
    check(first == d + 1, "R5 first valid cycle", first, d + 1);
    check(cnt == l, "R4 sample count", cnt, l);
    check(bad == 0, "R5 data words", bad, 0);
    check(status == 2'd0, "R4 idle after burst", status, 0);
  endtask

  task automatic run_loop(input int l, input int n);
    int bad;
    write_mode(2'd2, 0, l);
    check(status == 2'd2 && ram_rd, "R6 loop sends at once", status, 2);
    bad = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (!out_valid || out_data != word((k - 1) % l)) bad++;
    end
    check(bad == 0, "R6 R10 gapless wrapped data", bad, 0);
    write_mode(2'd0, 0, l);
    check(status == 2'd0, "R7 status idle after stop", status, 0);
    check(!out_valid, "R7 no valid after stop", out_valid, 0);
    bad = 0;
    repeat (3) begin @(negedge clk); if (out_valid || ram_rd) bad++; end
    check(bad == 0, "R7 stays stopped", bad, 0);
  endtask

  localparam int NV = 6;
  localparam logic [26:0] VEC [NV] = '{
    {15'd0,     12'd1},
    {15'd1,     12'd2},
    {15'd5,     12'd7},
    {15'd300,   12'd16},
    {15'd3,     12'd2048},
    {15'd32767, 12'd3}
  };

  initial begin
    #800000;
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(status == 2'd0 && !out_valid && !ram_rd, "R1 reset state", status, 0);

    for (int v = 0; v < NV; v++)
      run_burst(int'(VEC[v][26:12]), int'(VEC[v][11:0]), 1'b0);

    run_burst(2, 6, 1'b1);
    run_burst(4, 3, 1'b0);

    run_loop(5, 17);
    run_loop(1, 4);
    run_loop(2048, 2052);

    write_mode(2'd3, 0, 5);
    check(status == 2'd0, "R1 code 3 ignored", status, 0);

    bad = 0;
    trigger = 1; @(negedge clk); trigger = 0;
    repeat (3) begin @(negedge clk); if (ram_rd || out_valid || status != 0) bad++; end
    check(bad == 0, "R2 trigger ignored when idle", bad, 0);

    write_mode(2'd1, 0, 0);
    check(status == 2'd0, "R9 single length zero", status, 0);
    bad = 0;
    trigger = 1; @(negedge clk); trigger = 0;
    repeat (3) begin @(negedge clk); if (ram_rd || out_valid) bad++; end
    check(bad == 0, "R9 no reads after trigger", bad, 0);
    write_mode(2'd2, 0, 0);
    check(status == 2'd0 && !ram_rd, "R9 loop length zero", status, 0);

    summary();
  end

endmodule